// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit takes one 32-bit IEEE-754 single-precision word and, one clock later, presents a coarse estimate of its reciprocal together with three exception flags. It runs in a fixed vector-style arithmetic mode: subnormal operands are flushed to zero before anything else happens, and every NaN result is the one canonical quiet NaN. No rounding mode is selectable and no handshake exists. A new operand may be presented every cycle, and each result follows its operand by exactly one cycle.

For ordinary operands the result exponent is the input exponent negated about the bias, and the result significand comes from an 8-bit reciprocal table. The table is indexed by the leading eight fraction bits and computed at elaboration from the interval midpoints. Out-of-range and special operands (NaN, infinity, zero, subnormal, and very large magnitudes that would underflow) get fixed encodings that keep the sign of the input where one exists.

Top module: `recip_est_top`

## Requirements
- R1: Any NaN operand (exponent field 255, non-zero fraction), quiet or signalling, yields exactly 0x7FC00000 and never the input NaN.
- R2: The invalid flag (flags_o bit 2) is raised only for a signalling NaN operand, meaning fraction bit 22 is 0 with a non-zero fraction. A quiet NaN raises no flag.
- R3: An infinite operand yields a zero whose sign bit equals the operand sign (bit 31), and no flag is raised.
- R4: A zero operand yields an infinity (0x7F800000 with the operand sign in bit 31) and raises divide-by-zero (flags_o bit 0).
- R5: A subnormal operand (exponent field 0, non-zero fraction) is flushed to zero and behaves exactly as R4 with its own sign.
- R6: A finite operand with exponent field 253 or 254 yields a zero of the operand's sign and raises underflow (flags_o bit 1).
- R7: For a normal operand with exponent field E in 1..252, the result sign equals the operand sign, the result exponent field is 253 − E, and no flag is raised.
- R8: The result fraction bits 14:0 are always zero for normal operands. Bits 22:15 come from the table entry selected by operand fraction bits 22:15.
- R9: When operand fraction bits 22:15 are all zero, result fraction bits 22:15 are 0xFF.
- R10: For every normal operand below the underflow threshold, the product of operand and estimate is within a relative distance of 2^-7 from 1.
- R11: The result and flags reflect the operand sampled at the previous rising edge and stay stable until the next edge. A synchronous active-high reset clears the result and all flags to zero.
- R12: At most one flag is raised for any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 32 | Single-precision operand |
| est_o | output | 32 | Registered reciprocal estimate |
| flags_o | output | 3 | Registered flags: bit 2 invalid, bit 1 underflow, bit 0 divide-by-zero |

## Verification
The bench targets the sign of every special result. A design that hard-codes +0 or +inf would return a positive value for negative infinity, negative zero, negative subnormals and large negative operands. It feeds signalling and quiet NaNs with unusual payloads, which catches a design that passes the NaN through with its quiet bit set instead of returning the canonical value. It sweeps all 256 table indices across several exponents, including the last normal exponent 252 and the first underflowing exponent 253, and the power-of-two index. An off-by-one in the threshold, the exponent negation or the table formula therefore shows up as a wrong exponent or a product outside the error bound. A latency check catches a result that appears early or late.

// File: rtl/recip_pkg.sv
package recip_pkg;

    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int WORD_W   = 1 + EXP_W + FRAC_W;
    localparam int LUT_IDX_W = 8;
    localparam int LUT_PAD_W = FRAC_W - LUT_IDX_W;

    localparam logic [EXP_W-1:0] EXP_ALL_ONES = '1;
    localparam int               EXP_MIRROR   = 2 * ((1 << (EXP_W - 1)) - 1) - 1;
    localparam logic [EXP_W-1:0] TINY_LIMIT   = EXP_W'(EXP_MIRROR);

    localparam logic [WORD_W-1:0] CANON_NAN = {1'b0, EXP_ALL_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } sp_word_t;

    typedef struct packed {
        logic inv;
        logic uf;
        logic dz;
    } rcp_flags_t;

    typedef enum logic [2:0] {
        OPC_NORMAL,
        OPC_ZERO,
        OPC_INF,
        OPC_QNAN,
        OPC_SNAN,
        OPC_TINY
    } op_class_e;

    // Estimate of 2/m for m at the midpoint of interval idx, scaled by 2^IDX_W,
    // minus the hidden one. Index 0 saturates to the largest entry.
    function automatic logic [LUT_IDX_W-1:0] recip_entry(input int idx);
        int num;
        int den;
        int q;
        num = 1 << (2 * LUT_IDX_W + 2);
        den = (1 << (LUT_IDX_W + 1)) + 2 * idx + 1;
        q   = num / den - (1 << LUT_IDX_W);
        if (idx == 0 || q > (1 << LUT_IDX_W) - 1) begin
            q = (1 << LUT_IDX_W) - 1;
        end
        return LUT_IDX_W'(q);
    endfunction

endpackage

// File: rtl/recip_classify.sv
module recip_classify
    import recip_pkg::*;
(
    input  sp_word_t  word_i,
    output op_class_e cls_o
);
    logic exp_zero;
    logic exp_max;
    logic frac_zero;

    always_comb begin
        exp_zero  = (word_i.expo == '0);
        exp_max   = (word_i.expo == EXP_ALL_ONES);
        frac_zero = (word_i.frac == '0);

        if (exp_max && !frac_zero) begin
            cls_o = word_i.frac[FRAC_W-1] ? OPC_QNAN : OPC_SNAN;
        end else if (exp_max) begin
            cls_o = OPC_INF;
        end else if (exp_zero) begin
            // subnormals flush to zero
            cls_o = OPC_ZERO;
        end else if (word_i.expo >= TINY_LIMIT) begin
            cls_o = OPC_TINY;
        end else begin
            cls_o = OPC_NORMAL;
        end
    end
endmodule

// File: rtl/recip_mant_lut.sv
module recip_mant_lut
    import recip_pkg::*;
#(
    parameter int IDX_W = LUT_IDX_W
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] val_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = IDX_W'(recip_entry(g));
    end

    assign val_o = rom[idx_i];
endmodule

// File: rtl/recip_datapath.sv
module recip_datapath
    import recip_pkg::*;
(
    input  sp_word_t                word_i,
    input  op_class_e               cls_i,
    input  logic [LUT_IDX_W-1:0]    mant_i,
    output sp_word_t                res_o,
    output rcp_flags_t              flg_o
);
    logic [EXP_W-1:0] neg_exp;

    always_comb begin
        neg_exp = TINY_LIMIT - word_i.expo;
        res_o   = '0;
        flg_o   = '0;
        unique case (cls_i)
            OPC_QNAN: begin
                res_o = CANON_NAN;
            end
            OPC_SNAN: begin
                res_o     = CANON_NAN;
                flg_o.inv = 1'b1;
            end
            OPC_INF: begin
                res_o.sign = word_i.sign;
            end
            OPC_ZERO: begin
                res_o.sign = word_i.sign;
                res_o.expo = EXP_ALL_ONES;
                flg_o.dz   = 1'b1;
            end
            OPC_TINY: begin
                res_o.sign = word_i.sign;
                flg_o.uf   = 1'b1;
            end
            default: begin
                res_o.sign = word_i.sign;
                res_o.expo = neg_exp;
                res_o.frac = {mant_i, {LUT_PAD_W{1'b0}}};
            end
        endcase
    end
endmodule

// File: rtl/recip_est_top.sv
module recip_est_top
    import recip_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [31:0] op_i,
    output logic [31:0] est_o,
    output logic [2:0]  flags_o
);
    sp_word_t               word;
    op_class_e              cls;
    logic [LUT_IDX_W-1:0]   mant;
    sp_word_t               res_d;
    rcp_flags_t             flg_d;

    assign word = sp_word_t'(op_i);

    recip_classify u_cls (
        .word_i (word),
        .cls_o  (cls)
    );

    recip_mant_lut #(.IDX_W(LUT_IDX_W)) u_lut (
        .idx_i (word.frac[FRAC_W-1 -: LUT_IDX_W]),
        .val_o (mant)
    );

    recip_datapath u_dp (
        .word_i (word),
        .cls_i  (cls),
        .mant_i (mant),
        .res_o  (res_d),
        .flg_o  (flg_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            est_o   <= '0;
            flags_o <= '0;
        end else begin
            est_o   <= res_d;
            flags_o <= flg_d;
        end
    end

    AST_NAN_CANON: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(op_i[30:23]) == 8'hFF && $past(op_i[22:0]) != 23'd0)
        |-> est_o == 32'h7FC0_0000); // R1

    AST_INV_ONLY_SNAN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && flags_o[2])
        |-> ($past(op_i[30:23]) == 8'hFF && !$past(op_i[22]) && $past(op_i[21:0]) != 22'd0)); // R2

    AST_INF_SIGNED_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(op_i[30:0]) == 31'h7F80_0000)
        |-> (est_o == {$past(op_i[31]), 31'd0} && flags_o == 3'b000)); // R3

    AST_ZERO_SIGNED_INF: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(op_i[30:23]) == 8'h00)
        |-> (est_o == {$past(op_i[31]), 31'h7F80_0000} && flags_o == 3'b001)); // R4

    AST_TINY_UNDERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && ($past(op_i[30:23]) == 8'd253 || $past(op_i[30:23]) == 8'd254))
        |-> (est_o == {$past(op_i[31]), 31'd0} && flags_o == 3'b010)); // R6

    AST_NORMAL_EXP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(op_i[30:23]) != 8'd0 && $past(op_i[30:23]) < 8'd253)
        |-> (est_o[31] == $past(op_i[31]) && est_o[30:23] == 8'd253 - $past(op_i[30:23])
             && est_o[14:0] == 15'd0 && flags_o == 3'b000)); // R7

    AST_POW2_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(op_i[30:23]) != 8'd0 && $past(op_i[30:23]) < 8'd253
         && $past(op_i[22:15]) == 8'd0)
        |-> est_o[22:15] == 8'hFF); // R9

    AST_FLAGS_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(flags_o)); // R12

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $stable(op_i)) |=> $stable(est_o)); // R11
endmodule

// File: tb/recip_est_top_test.sv
module recip_est_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op  = 32'd0;
    logic [31:0] est_o;
    logic [2:0]  flags_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    recip_est_top uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .op_i    (op),
        .est_o   (est_o),
        .flags_o (flags_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s op=%h actual=%h expected=%h", req, op, act, exp_v);
        end
    endtask

    // Drive at the falling edge, let one rising edge capture it, sample just after.
    task automatic apply(input logic [31:0] v);
        @(negedge clk);
        op = v;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_word(input logic [31:0] v, input logic [31:0] e_res, input logic [2:0] e_flg, input string req);
        apply(v);
        check(est_o == e_res, req, est_o, e_res);
        check(flags_o == e_flg, req, {29'd0, flags_o}, {29'd0, e_flg});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        op  = 32'h7F80_0001;
        repeat (2) @(posedge clk);
        #1;
        check(est_o == 32'd0 && flags_o == 3'd0, "R11 reset", est_o, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_nan();
        expect_word(32'h7FC0_0000, 32'h7FC0_0000, 3'b000, "R1 qnan");
        expect_word(32'hFFC1_2345, 32'h7FC0_0000, 3'b000, "R2 neg qnan no flag");
        expect_word(32'h7F80_0001, 32'h7FC0_0000, 3'b100, "R2 snan invalid");
        expect_word(32'hFFA0_0000, 32'h7FC0_0000, 3'b100, "R1 neg snan canon");
    endtask

    task automatic t_inf();
        expect_word(32'h7F80_0000, 32'h0000_0000, 3'b000, "R3 +inf");
        expect_word(32'hFF80_0000, 32'h8000_0000, 3'b000, "R3 -inf");
    endtask

    task automatic t_zero();
        expect_word(32'h0000_0000, 32'h7F80_0000, 3'b001, "R4 +0");
        expect_word(32'h8000_0000, 32'hFF80_0000, 3'b001, "R4 -0");
        expect_word(32'h0000_0001, 32'h7F80_0000, 3'b001, "R5 +denorm");
        expect_word(32'h807F_FFFF, 32'hFF80_0000, 3'b001, "R5 -denorm");
    endtask

    task automatic t_underflow();
        expect_word({1'b0, 8'd253, 23'd0},        32'h0000_0000, 3'b010, "R6 exp253");
        expect_word({1'b1, 8'd253, 23'h12345},    32'h8000_0000, 3'b010, "R6 -exp253");
        expect_word({1'b1, 8'd254, 23'h7FFFFF},   32'h8000_0000, 3'b010, "R6 -exp254");
    endtask

    task automatic check_normal(input logic [31:0] v);
        real mx;
        real me;
        real err;
        logic [7:0] e_exp;
        apply(v);
        e_exp = 8'd253 - v[30:23];
        check(est_o[31] == v[31], "R7 sign", est_o, v);
        check(est_o[30:23] == e_exp, "R7 exponent", {24'd0, est_o[30:23]}, {24'd0, e_exp});
        check(flags_o == 3'd0, "R7 no flag", {29'd0, flags_o}, 32'd0);
        check(est_o[14:0] == 15'd0, "R8 low fraction zero", est_o, {est_o[31:15], 15'd0});
        if (v[22:15] == 8'd0) begin
            check(est_o[22:15] == 8'hFF, "R9 power-of-two index", {24'd0, est_o[22:15]}, 32'hFF);
        end
        mx  = 1.0 + real'(v[22:0]) / 8388608.0;
        me  = 1.0 + real'(est_o[22:0]) / 8388608.0;
        err = mx * me / 2.0 - 1.0;
        if (err < 0.0) err = -err;
        check(err <= 1.0 / 128.0, "R10 accuracy", est_o, v);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 256; i++) begin
            logic [7:0] ex;
            logic [14:0] low;
            ex  = 8'(1 + (i * 37) % 252);
            low = 15'(i * 97 + 3);
            check_normal({i[0], ex, i[7:0], low});
            check_normal({~i[0], 8'd127, i[7:0], 15'h7FFF});
        end
    endtask

    task automatic t_bounds();
        check_normal({1'b0, 8'd252, 23'd0});
        check_normal({1'b1, 8'd252, 23'h7FFFFF});
        check_normal({1'b0, 8'd1, 23'd0});
        check_normal({1'b1, 8'd127, 23'd0});
    endtask

    task automatic t_latency();
        logic [31:0] held;
        apply(32'h3F80_0000);
        held = est_o;
        @(negedge clk);
        op = 32'h0000_0000;
        #1;
        check(est_o == held, "R11 holds until edge", est_o, held);
        @(posedge clk);
        #1;
        check(est_o == 32'h7F80_0000, "R11 one-cycle update", est_o, 32'h7F80_0000);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(est_o == 32'd0 && flags_o == 3'd0, "R11 reset mid-run", est_o, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_exclusive();
        logic [31:0] pats [6] = '{32'h7F80_0002, 32'h0000_0000, 32'h7E80_0000,
                                  32'h7F80_0000, 32'h4000_0000, 32'hFFC0_0001};
        for (int k = 0; k < 6; k++) begin
            apply(pats[k]);
            check($countones(flags_o) <= 1, "R12 single flag", {29'd0, flags_o}, 32'd0);
        end
    endtask

    initial begin
        t_reset();
        t_nan();
        t_inf();
        t_zero();
        t_underflow();
        t_bounds();
        t_sweep();
        t_exclusive();
        t_latency();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule